// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the combinational steering logic of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It looks at the instruction class codes sitting in the decode, execute and memory pipeline registers. It also looks at the two source register IDs of the decode-stage instruction, the register that the execute-stage instruction will load from memory, and the condition result computed in execute. From these it decides, for every pipeline register, whether that register loads normally, holds its contents (stall) or loads a no-op (bubble) on the next clock edge.

Three hazard events are detected:

- A load/use conflict: the execute stage holds a load or a pop whose memory destination is read by the decode-stage instruction.
- A mispredicted branch: every branch is predicted taken, so a conditional jump in execute whose condition is false was mispredicted.
- A return in flight: a return instruction is somewhere in decode, execute or memory.

Each cycle the events are folded into exactly one named scenario: `SC_CLEAR`, `SC_LOAD_USE`, `SC_MISPREDICT`, `SC_RETURN`, `SC_RET_MISPREDICT` or `SC_RET_LOAD_USE`. A table maps the scenario to a per-stage action (`ACT_NORMAL`, `ACT_STALL`, `ACT_BUBBLE`). No state is kept, so there are no transitions. The scenario is re-derived from scratch every cycle, and the pipeline registers outside this block carry the actions out at the next edge.

Top module: `hzd_ctrl`

## Requirements
- R1: A load/use conflict exists only when the execute class is LOAD (4'h2) or POP (4'h3) and the execute memory destination equals the decode source A or source B. Any other execute class never causes it.
- R2: On a load/use conflict alone, fetch (bit 0) and decode (bit 1) stall, execute (bit 2) gets a bubble, and no other stall or bubble bit is set. Bits of `stage_stall`/`stage_bubble` are indexed fetch=0, decode=1, execute=2, memory=3, write-back=4.
- R3: When the execute class is JCC (4'h5) and `exe_cond_ok` is 0, decode and execute get bubbles and nothing stalls. With `exe_cond_ok` 1, no action is taken.
- R4: While class RET (4'h6) sits in decode, execute or memory (and no other event is present), fetch stalls and decode gets a bubble.
- R5: A return in flight together with a mispredicted branch gives a fetch stall plus decode and execute bubbles.
- R6: A return in flight together with a load/use conflict gives fetch and decode stalls and an execute bubble. The decode bubble is suppressed, so the return stays in decode.
- R7: Register ID 4'hF means "no operand" and never produces a load/use match, even when source and destination are both 4'hF.
- R8: The memory and write-back stall and bubble outputs and the fetch bubble output are always 0.
- R9: No pipeline register ever receives stall and bubble in the same cycle.
- R10: With no event present, all stall and bubble outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_cls | input | 4 | Class code of the instruction in the decode register |
| exe_cls | input | 4 | Class code of the instruction in the execute register |
| mem_cls | input | 4 | Class code of the instruction in the memory register |
| dec_src_a | input | 4 | First source register ID of the decode instruction (4'hF = none) |
| dec_src_b | input | 4 | Second source register ID of the decode instruction (4'hF = none) |
| exe_dst_mem | input | 4 | Memory-load destination register ID of the execute instruction (4'hF = none) |
| exe_cond_ok | input | 1 | Branch condition result of the execute instruction (1 = taken) |
| stage_stall | output | 5 | Hold request per pipeline register, bit 0 fetch to bit 4 write-back |
| stage_bubble | output | 5 | No-op insertion request per pipeline register, bit 0 fetch to bit 4 write-back |

## Verification
The bench goes after the coincidence cases. A return in decode that meets a load/use conflict must give a decode stall without a bubble; a design that lets the return's bubble through would drive decode with both stall and bubble at once. A return at a mispredicted branch target must still carry the execute bubble, or a wrong-path instruction would run on. The bench also checks the "no operand" ID 4'hF: a design that compares it like a normal register stalls on every instruction that has no operand. Finally, a long pseudo-random sweep over class codes and register IDs is compared against an independent model, and every cycle it is checked that stall and bubble never coincide on any stage.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    parameter int CLS_W   = 4;
    parameter int REG_W   = 4;
    parameter int N_STAGE = 5;
    parameter int N_RETSTG = 3;

    localparam logic [CLS_W-1:0] CLS_LOAD = CLS_W'(4'h2);
    localparam logic [CLS_W-1:0] CLS_POP  = CLS_W'(4'h3);
    localparam logic [CLS_W-1:0] CLS_JCC  = CLS_W'(4'h5);
    localparam logic [CLS_W-1:0] CLS_RET  = CLS_W'(4'h6);
    localparam logic [REG_W-1:0] REG_NONE = '1;

    localparam int STG_F = 0;
    localparam int STG_D = 1;
    localparam int STG_E = 2;
    localparam int STG_M = 3;
    localparam int STG_W = 4;

    typedef enum logic [1:0] {
        ACT_NORMAL,
        ACT_STALL,
        ACT_BUBBLE
    } act_t;

    typedef enum logic [2:0] {
        SC_CLEAR,
        SC_LOAD_USE,
        SC_MISPREDICT,
        SC_RETURN,
        SC_RET_MISPREDICT,
        SC_RET_LOAD_USE
    } scen_t;
endpackage

// File: rtl/hzd_detect.sv
module hzd_detect
    import hzd_pkg::*;
(
    input  logic [N_RETSTG-1:0][CLS_W-1:0] ret_window,
    input  logic [CLS_W-1:0]               exe_cls,
    input  logic [REG_W-1:0]               src_a,
    input  logic [REG_W-1:0]               src_b,
    input  logic [REG_W-1:0]               dst_mem,
    input  logic                           cond_ok,
    output logic                           load_use,
    output logic                           mispredict,
    output logic                           ret_active
);
    logic [N_RETSTG-1:0] ret_hit;
    logic                is_load;
    logic                match_a;
    logic                match_b;

    genvar g;
    generate
        for (g = 0; g < N_RETSTG; g++) begin : g_ret
            assign ret_hit[g] = (ret_window[g] == CLS_RET);
        end
    endgenerate

    always_comb begin
        is_load    = (exe_cls == CLS_LOAD) || (exe_cls == CLS_POP);
        match_a    = (dst_mem != REG_NONE) && (dst_mem == src_a);
        match_b    = (dst_mem != REG_NONE) && (dst_mem == src_b);
        load_use   = is_load && (match_a || match_b);
        mispredict = (exe_cls == CLS_JCC) && !cond_ok;
        ret_active = |ret_hit;
    end

    always_comb begin
        if (!$isunknown({dst_mem, exe_cls, src_a, src_b})) begin
            // R7: the no-operand ID never yields a conflict
            assert_none_id_R7: assert (!(dst_mem == REG_NONE && load_use));
            // R1: only load-class execute instructions can conflict
            assert_load_class_R1: assert (!load_use || exe_cls == CLS_LOAD || exe_cls == CLS_POP);
        end
    end
endmodule

// File: rtl/hzd_scenario.sv
module hzd_scenario
    import hzd_pkg::*;
(
    input  logic                load_use,
    input  logic                mispredict,
    input  logic                ret_active,
    output scen_t               scen,
    output act_t [N_STAGE-1:0]  acts
);
    // scenario selection: load/use outranks the return's decode bubble
    always_comb begin
        if (ret_active && load_use)        scen = SC_RET_LOAD_USE;
        else if (ret_active && mispredict) scen = SC_RET_MISPREDICT;
        else if (load_use)                 scen = SC_LOAD_USE;
        else if (mispredict)               scen = SC_MISPREDICT;
        else if (ret_active)               scen = SC_RETURN;
        else                               scen = SC_CLEAR;
    end

    // per-stage action table
    always_comb begin
        acts = {N_STAGE{ACT_NORMAL}};
        unique case (scen)
            SC_CLEAR: ;
            SC_LOAD_USE, SC_RET_LOAD_USE: begin
                acts[STG_F] = ACT_STALL;
                acts[STG_D] = ACT_STALL;
                acts[STG_E] = ACT_BUBBLE;
            end
            SC_MISPREDICT: begin
                acts[STG_D] = ACT_BUBBLE;
                acts[STG_E] = ACT_BUBBLE;
            end
            SC_RETURN: begin
                acts[STG_F] = ACT_STALL;
                acts[STG_D] = ACT_BUBBLE;
            end
            SC_RET_MISPREDICT: begin
                acts[STG_F] = ACT_STALL;
                acts[STG_D] = ACT_BUBBLE;
                acts[STG_E] = ACT_BUBBLE;
            end
            default: acts = {N_STAGE{ACT_NORMAL}};
        endcase
    end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
    import hzd_pkg::*;
(
    input  logic [CLS_W-1:0]   dec_cls,
    input  logic [CLS_W-1:0]   exe_cls,
    input  logic [CLS_W-1:0]   mem_cls,
    input  logic [REG_W-1:0]   dec_src_a,
    input  logic [REG_W-1:0]   dec_src_b,
    input  logic [REG_W-1:0]   exe_dst_mem,
    input  logic               exe_cond_ok,
    output logic [N_STAGE-1:0] stage_stall,
    output logic [N_STAGE-1:0] stage_bubble
);
    logic               load_use;
    logic               mispredict;
    logic               ret_active;
    scen_t              scen;
    act_t [N_STAGE-1:0] acts;

    hzd_detect u_detect (
        .ret_window ({mem_cls, exe_cls, dec_cls}),
        .exe_cls    (exe_cls),
        .src_a      (dec_src_a),
        .src_b      (dec_src_b),
        .dst_mem    (exe_dst_mem),
        .cond_ok    (exe_cond_ok),
        .load_use   (load_use),
        .mispredict (mispredict),
        .ret_active (ret_active)
    );

    hzd_scenario u_scen (
        .load_use   (load_use),
        .mispredict (mispredict),
        .ret_active (ret_active),
        .scen       (scen),
        .acts       (acts)
    );

    genvar s;
    generate
        for (s = 0; s < N_STAGE; s++) begin : g_stage
            assign stage_stall[s]  = (acts[s] == ACT_STALL);
            assign stage_bubble[s] = (acts[s] == ACT_BUBBLE);
        end
    endgenerate

    always_comb begin
        if (!$isunknown({dec_cls, exe_cls, mem_cls, dec_src_a, dec_src_b, exe_dst_mem, exe_cond_ok})) begin
            assert_no_dual_R9: assert ((stage_stall & stage_bubble) == '0);
            assert_lu_priority_R6: assert (!(load_use && ret_active) ||
                                           (stage_stall[STG_D] && !stage_bubble[STG_D]));
            assert_mispredict_R3: assert (!mispredict ||
                                          (stage_bubble[STG_D] && stage_bubble[STG_E]));
            assert_tail_idle_R8: assert (stage_stall[STG_W:STG_M] == '0 &&
                                         stage_bubble[STG_W:STG_M] == '0 &&
                                         !stage_bubble[STG_F]);
            assert_ret_hold_R4: assert (!ret_active || stage_stall[STG_F]);
        end
    end
endmodule

// File: tb/tb_hzd_ctrl.sv
module tb_hzd_ctrl;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0] dec_cls = 4'h0, exe_cls = 4'h0, mem_cls = 4'h0;
    logic [3:0] src_a = 4'hF, src_b = 4'hF, dst = 4'hF;
    logic       cond = 1'b1;
    logic [4:0] st, bu;

    int checks = 0;
    int errors = 0;

    hzd_ctrl dut (
        .dec_cls(dec_cls), .exe_cls(exe_cls), .mem_cls(mem_cls),
        .dec_src_a(src_a), .dec_src_b(src_b), .exe_dst_mem(dst),
        .exe_cond_ok(cond), .stage_stall(st), .stage_bubble(bu)
    );

    // fields: req, dec, exe, mem, srcA, srcB, dst, cond, stall[4:0], bubble[4:0]
    localparam int NV = 14;
    localparam logic [38:0] VEC [NV] = '{
        {4'd10, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00000, 5'b00000}, // R10 idle
        {4'd2,  4'h0, 4'h2, 4'h0, 4'h3, 4'hF, 4'h3, 1'b1, 5'b00011, 5'b00100}, // R2 load, src A
        {4'd1,  4'h0, 4'h3, 4'h0, 4'hF, 4'h4, 4'h4, 1'b1, 5'b00011, 5'b00100}, // R1 pop, src B
        {4'd1,  4'h0, 4'h2, 4'h0, 4'h1, 4'h2, 4'h3, 1'b1, 5'b00000, 5'b00000}, // R1 no match
        {4'd7,  4'h0, 4'h2, 4'h0, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00000, 5'b00000}, // R7 none id
        {4'd3,  4'h0, 4'h5, 4'h0, 4'h1, 4'h2, 4'hF, 1'b0, 5'b00000, 5'b00110}, // R3 mispredict
        {4'd3,  4'h0, 4'h5, 4'h0, 4'h1, 4'h2, 4'hF, 1'b1, 5'b00000, 5'b00000}, // R3 taken
        {4'd4,  4'h6, 4'h0, 4'h0, 4'h4, 4'hF, 4'hF, 1'b1, 5'b00001, 5'b00010}, // R4 ret in D
        {4'd4,  4'h0, 4'h6, 4'h0, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00001, 5'b00010}, // R4 ret in E
        {4'd4,  4'h0, 4'h0, 4'h6, 4'hF, 4'hF, 4'hF, 1'b1, 5'b00001, 5'b00010}, // R4 ret in M
        {4'd5,  4'h6, 4'h5, 4'h0, 4'h4, 4'hF, 4'hF, 1'b0, 5'b00001, 5'b00110}, // R5 ret at target
        {4'd6,  4'h6, 4'h2, 4'h0, 4'h4, 4'hF, 4'h4, 1'b1, 5'b00011, 5'b00100}, // R6 ret + load
        {4'd6,  4'h1, 4'h3, 4'h6, 4'h5, 4'hF, 4'h5, 1'b1, 5'b00011, 5'b00100}, // R6 ret in M + pop
        {4'd1,  4'h0, 4'h1, 4'h0, 4'h3, 4'hF, 4'h3, 1'b1, 5'b00000, 5'b00000}  // R1 non-load class
    };

    task automatic drive(input logic [3:0] d, e, m, a, b, x, input logic c);
        @(posedge clk);
        dec_cls = d; exe_cls = e; mem_cls = m;
        src_a = a; src_b = b; dst = x; cond = c;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [4:0] es, input logic [4:0] eb);
        checks++;
        if (st !== es || bu !== eb) begin
            errors++;
            $display("FAIL %s: stall=%b bubble=%b expected stall=%b bubble=%b", tag, st, bu, es, eb);
        end
    endtask

    // independent model written from the requirements
    function automatic logic [9:0] model(input logic [3:0] d, e, m, a, b, x, input logic c);
        logic lu, mp, rt;
        logic [4:0] s, u;
        lu = (e == 4'h2 || e == 4'h3) && x != 4'hF && (x == a || x == b);
        mp = (e == 4'h5) && !c;
        rt = (d == 4'h6) || (e == 4'h6) || (m == 4'h6);
        s = 5'b0; u = 5'b0;
        if (lu) begin s[0] = 1; s[1] = 1; u[2] = 1; end
        if (mp) begin u[1] = 1; u[2] = 1; end
        if (rt) begin s[0] = 1; if (!lu) u[1] = 1; end
        return {s, u};
    endfunction

    function automatic logic [3:0] pick_cls(input int r);
        logic [3:0] t [6] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h5, 4'h6};
        return t[r % 6];
    endfunction

    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // reset-like idle state: R10
        @(negedge clk);
        check("R10 idle at start", 5'b0, 5'b0);

        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            v = VEC[i];
            drive(v[34:31], v[30:27], v[26:23], v[22:19], v[18:15], v[14:11], v[10]);
            check($sformatf("R%0d vector %0d", v[38:35], i), v[9:5], v[4:0]);
        end

        // R7: all IDs 0xF with a pop in execute
        drive(4'h0, 4'h3, 4'h0, 4'hF, 4'hF, 4'hF, 1'b1);
        check("R7 pop with none ids", 5'b0, 5'b0);
        // R8 / R9 under all events at once
        drive(4'h6, 4'h2, 4'h6, 4'h7, 4'h7, 4'h7, 1'b0);
        check("R8 R9 stacked events", 5'b00011, 5'b00100);

        // random sweep against the model; R9 checked each step
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] d, e, m, a, b, x;
            logic c;
            logic [9:0] exp;
            d = pick_cls($urandom); e = pick_cls($urandom); m = pick_cls($urandom);
            a = 4'($urandom % 6 + 10); b = 4'($urandom % 6 + 10); x = 4'($urandom % 6 + 10);
            c = 1'($urandom);
            drive(d, e, m, a, b, x, c);
            exp = model(d, e, m, a, b, x, c);
            check("R1 R3 R4 R5 R6 random", exp[9:5], exp[4:0]);
            checks++;
            if ((st & bu) != 5'b0) begin
                errors++;
                $display("FAIL R9: overlap=%b expected 00000", st & bu);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule